// File: doc/BRIEF.md
# Triggered Capture Memory

This block records a stream of WIDTH-bit samples into a DEPTH-entry memory around a trigger event, much like the capture buffer of an on-chip logic analyzer. Each clock cycle with the enable input high supplies one sample. The trigger is an event qualified by the same enable. A build-time mode parameter sets where the recorded window sits relative to that event. The window can hold only history before the trigger, only what follows it, or a split window with the trigger sample in the middle.

When the window is full, the done flag rises. It stays high and the stored contents are frozen until reset. Reset is the only way to arm the block for a new capture. The contents are read through a synchronous port. The read address is remapped so that address 0 always returns the oldest sample of the window and higher addresses return newer ones. Entries that the window needs but that were never written read back as zero.

Top module: `trig_capture`

## Requirements
- R1: A sample is written only on a rising clock edge where en is 1. Cycles with en at 0 store nothing and do not advance the window.
- R2: A trigger is detected only at an edge where en and trig are both 1. A trig pulse with en at 0 is ignored, and only the first detected trigger after reset counts.
- R3: With MODE=0, the window holds the DEPTH enabled samples taken before the trigger edge. The trigger-edge sample is not stored, and done is 1 right after the trigger edge.
- R4: With MODE=1, nothing is stored before the trigger. The window holds the trigger-edge sample followed by the next DEPTH-1 enabled samples.
- R5: With MODE=2, the window holds the DEPTH/2-1 enabled samples before the trigger, then the trigger-edge sample, then the next DEPTH/2 enabled samples.
- R6: done rises right after the edge that completes the window. It then stays 1 until reset, and later samples and triggers leave the contents unchanged.
- R7: Read address a returns the a-th oldest sample of the window. Address 0 is the oldest and address DEPTH-1 the newest.
- R8: A window position that was never written (too little history in MODE 0 or 2) reads as 0.
- R9: data_out shows the entry for the addr sampled at a clock edge right after that edge, a latency of one cycle.
- R10: A synchronous reset (rst=1 at an edge) clears done, makes every address read 0, and rearms the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset and rearm, active high |
| en | input | 1 | Sample enable; also qualifies trig |
| data_in | input | WIDTH | Sample to record |
| trig | input | 1 | Trigger request |
| addr | input | $clog2(DEPTH) | Read address, 0 is the oldest sample |
| data_out | output | WIDTH | Read data, one cycle after addr |
| done | output | 1 | Window complete, held until reset |

## Verification
The assertions assume that rst is held high for at least one edge before any capture, and that en and trig are never unknown once reset is released. Under these assumptions, the write pointer moves only on enabled writes and freezes after done, and in the post-only mode it stays at zero until the trigger arrives. The stimulus meets these assumptions: it drives only defined values on the falling clock edge and holds reset for two cycles before every run. Each run feeds all three mode variants the same sample stream. That stream includes enable gaps, trig pulses with enable low, trig pulses while filling after the trigger, and samples after done.

// File: rtl/cap_pkg.sv
package cap_pkg;

   typedef enum logic [1:0] {
      CAP_ARMED = 2'd0,
      CAP_POST  = 2'd1,
      CAP_DONE  = 2'd2
   } cap_state_e;

   // writes still owed after the trigger-edge write, per mode
   function automatic int post_len(input int depth, input int mode);
      case (mode)
         1:       return depth - 1;
         2:       return depth / 2;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/cap_ctrl.sv
module cap_ctrl
   import cap_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int MODE  = 2,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   input  logic          trig,
   output logic          we,
   output logic [AW-1:0] wptr,
   output logic          done,
   output logic          armed
);

   localparam int CW     = AW + 1;
   localparam int POST_N = post_len(DEPTH, MODE);

   cap_state_e    state;
   logic [CW-1:0] remain;
   logic          hit;
   logic          arm_we;
   cap_state_e    after_hit;

   assign hit = en && trig;

   generate
      if (MODE == 0) begin : g_pre
         assign arm_we    = en && !trig;
         assign after_hit = CAP_DONE;
      end else if (MODE == 1) begin : g_post
         assign arm_we    = hit;
         assign after_hit = CAP_POST;
      end else begin : g_split
         assign arm_we    = en;
         assign after_hit = CAP_POST;
      end
   endgenerate

   always_comb begin
      case (state)
         CAP_ARMED: we = arm_we;
         CAP_POST:  we = en;
         default:   we = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= CAP_ARMED;
         wptr   <= '0;
         remain <= '0;
      end else begin
         if (we) wptr <= wptr + 1'b1;
         case (state)
            CAP_ARMED: begin
               if (hit) begin
                  state  <= after_hit;
                  remain <= CW'(POST_N);
               end
            end
            CAP_POST: begin
               if (en) begin
                  remain <= remain - 1'b1;
                  if (remain == CW'(1)) state <= CAP_DONE;
               end
            end
            default: state <= CAP_DONE;
         endcase
      end
   end

   assign done  = (state == CAP_DONE);
   assign armed = (state == CAP_ARMED);

endmodule

// File: rtl/cap_readmap.sv
module cap_readmap #(
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] base,
   output logic [AW-1:0] phys
);
   // oldest entry sits at the next write slot; wrap is implicit in AW bits
   assign phys = addr + base;
endmodule

// File: rtl/cap_store.sv
module cap_store #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [DEPTH-1:0] filled;

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         filled <= '0;
         rdata  <= '0;
      end else begin
         if (we) filled[waddr] <= 1'b1;
         rdata <= filled[raddr] ? mem[raddr] : '0;
      end
   end

endmodule

// File: rtl/trig_capture.sv
module trig_capture #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16,
   parameter int MODE  = 2,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [WIDTH-1:0] data_in,
   input  logic             trig,
   input  logic [AW-1:0]    addr,
   output logic [WIDTH-1:0] data_out,
   output logic             done
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("trig_capture: WIDTH must be at least 1");
      end
      if (DEPTH < 4 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("trig_capture: DEPTH must be a power of two, 4 or more");
      end
      if (MODE < 0 || MODE > 2) begin : g_bad_mode
         $error("trig_capture: MODE must be 0, 1 or 2");
      end
   endgenerate

   logic          we;
   logic [AW-1:0] wptr;
   logic [AW-1:0] phys;
   logic          armed;

   cap_ctrl #(.DEPTH(DEPTH), .MODE(MODE)) u_ctrl (
      .clk   (clk),
      .rst   (rst),
      .en    (en),
      .trig  (trig),
      .we    (we),
      .wptr  (wptr),
      .done  (done),
      .armed (armed)
   );

   cap_readmap #(.DEPTH(DEPTH)) u_map (
      .addr (addr),
      .base (wptr),
      .phys (phys)
   );

   cap_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .rst   (rst),
      .we    (we),
      .waddr (wptr),
      .wdata (data_in),
      .raddr (phys),
      .rdata (data_out)
   );

endmodule

// File: rtl/trig_capture_chk.sv
module trig_capture_chk #(
   parameter int DEPTH = 16,
   parameter int MODE  = 2,
   localparam int AW   = $clog2(DEPTH)
) (
   input logic          clk,
   input logic          rst,
   input logic          en,
   input logic          done,
   input logic          we,
   input logic          armed,
   input logic [AW-1:0] wptr
);

   assert_en_gate_R1: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(wptr));

   assert_ptr_step_R7: assert property (@(posedge clk) disable iff (rst)
      we |=> wptr == AW'($past(wptr) + 1'b1));

   assert_done_cause_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(done) |-> $past(en));

   assert_idle_ptr_R4: assert property (@(posedge clk) disable iff (rst)
      (MODE == 1 && armed) |-> wptr == '0);

   assert_done_sticky_R6: assert property (@(posedge clk) disable iff (rst)
      done |=> done);

   assert_frozen_R6: assert property (@(posedge clk) disable iff (rst)
      done |=> $stable(wptr));

   assert_rearm_R10: assert property (@(posedge clk)
      rst |=> !done && armed);

endmodule

bind trig_capture trig_capture_chk #(.DEPTH(DEPTH), .MODE(MODE)) u_chk (
   .clk   (clk),
   .rst   (rst),
   .en    (en),
   .done  (done),
   .we    (we),
   .armed (armed),
   .wptr  (wptr)
);

// File: tb/test_trig_capture.sv
`timescale 1ns/1ps
module test_trig_capture;

   localparam int W  = 8;
   localparam int D  = 16;
   localparam int AW = $clog2(D);
   localparam int NV = 4;
   // per vector: {pre-trigger enabled samples, data seed}
   localparam int VEC [NV][2] = '{'{0, 3}, '{3, 5}, '{7, 11}, '{20, 2}};

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          en = 1'b0;
   logic          trig = 1'b0;
   logic [W-1:0]  data_in = '0;
   logic [AW-1:0] addr = '0;
   logic [W-1:0]  dout [3];
   logic          done [3];

   int vectors = 0;
   int miscompares = 0;

   logic [W-1:0] hist [64];
   int n = 0;
   int t = 0;
   bit tseen = 1'b0;
   int seed = 0;

   always #2.5 clk = ~clk;

   trig_capture #(.WIDTH(W), .DEPTH(D), .MODE(0)) i_trig_capture (
      .clk(clk), .rst(rst), .en(en), .data_in(data_in), .trig(trig),
      .addr(addr), .data_out(dout[0]), .done(done[0]));
   trig_capture #(.WIDTH(W), .DEPTH(D), .MODE(1)) i_trig_capture_m1 (
      .clk(clk), .rst(rst), .en(en), .data_in(data_in), .trig(trig),
      .addr(addr), .data_out(dout[1]), .done(done[1]));
   trig_capture #(.WIDTH(W), .DEPTH(D), .MODE(2)) i_trig_capture_m2 (
      .clk(clk), .rst(rst), .en(en), .data_in(data_in), .trig(trig),
      .addr(addr), .data_out(dout[2]), .done(done[2]));

   task automatic check(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] sample(input int s, input int k);
      return {1'b1, 7'(s * 29 + k * 11)};
   endfunction

   // expected read value at address a for the given mode (R3, R4, R5, R7, R8)
   function automatic int expect_at(input int mode, input int a);
      int base, idx;
      if (!tseen) return 0;
      base = (mode == 0) ? t - D : (mode == 1) ? t : t - (D / 2 - 1);
      idx = base + a;
      if (idx < 0 || idx >= n) return 0;
      return int'(hist[idx]);
   endfunction

   // entered and left at a falling edge; one rising edge in between
   task automatic step(input bit e, input bit tg);
      en = e;
      trig = tg;
      data_in = sample(seed, n);
      if (e) begin
         hist[n] = data_in;
         if (tg && !tseen) begin
            t = n;
            tseen = 1'b1;
         end
         n++;
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      en = 1'b0;
      trig = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      n = 0;
      tseen = 1'b0;
   endtask

   task automatic read_all(input string tag);
      for (int a = 0; a < D; a++) begin
         addr = AW'(a);
         @(posedge clk);
         @(negedge clk);
         for (int m = 0; m < 3; m++)
            check($sformatf("%s R7 R9 mode%0d addr%0d", tag, m, a),
                  int'(dout[m]), expect_at(m, a));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();
      for (int m = 0; m < 3; m++) check("R10 done after reset", int'(done[m]), 0);

      for (int v = 0; v < NV; v++) begin
         int pc;
         do_reset();
         seed = VEC[v][1];
         // pre-trigger: enable gaps carrying trig (R1, R2)
         for (int k = 0; k < VEC[v][0]; k++) begin
            if (k % 3 == 2) step(1'b0, 1'b1);
            step(1'b1, 1'b0);
         end
         for (int m = 0; m < 3; m++) check("R2 no trigger with en low", int'(done[m]), 0);
         step(1'b1, 1'b1);
         check("R3 mode0 done after trigger", int'(done[0]), 1);
         check("R4 mode1 filling", int'(done[1]), 0);
         check("R5 mode2 filling", int'(done[2]), 0);
         pc = 0;
         for (int j = 0; j < 24; j++) begin
            bit e;
            e = (j % 4 != 3);
            step(e, j % 5 == 0);
            if (e) pc++;
            check("R6 mode0 done held", int'(done[0]), 1);
            check("R4 R6 mode1 done", int'(done[1]), int'(pc >= D - 1));
            check("R5 R6 mode2 done", int'(done[2]), int'(pc >= D / 2));
         end
         en = 1'b0;
         trig = 1'b0;
         read_all($sformatf("vec%0d R8", v));
      end

      // reset mid-capture clears contents and done (R10)
      do_reset();
      seed = 9;
      step(1'b1, 1'b1);
      step(1'b1, 1'b0);
      step(1'b1, 1'b0);
      do_reset();
      for (int m = 0; m < 3; m++) check("R10 done cleared mid-capture", int'(done[m]), 0);
      read_all("R10 cleared");

      // en low for a long stretch stores nothing, trig ignored (R1, R2)
      seed = 13;
      for (int k = 0; k < 5; k++) step(1'b0, 1'b1);
      for (int m = 0; m < 3; m++) check("R2 trig ignored", int'(done[m]), 0);
      read_all("R1 nothing stored");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule